// File: doc/BRIEF.md
# Vertical Blank Status Flag and NMI Generator

This block keeps the vertical-blank status bit of a video timing unit and drives the processor's active-low non-maskable interrupt line. The frame counter supplies two one-dot pulses, one on the first dot of vertical blank (the set dot) and one on the dot where blanking ends. The CPU side supplies a status-read strobe that is aligned to a single dot and a level that enables or disables the interrupt. The block returns the flag value that a status read on the current dot would see, and it holds the interrupt line low while the flag and the enable are both true.

All timing is resolved to the dot, including the races around the set dot. A read on the dot just before the set dot cancels the flag for the whole frame. A read on the set dot, or on the dot after it, returns a set flag but prevents the interrupt. Changes to the enable close to the set dot decide whether an interrupt fires at all. Raising the enable while the flag is already set produces a new falling edge. Toggling the enable therefore gives several interrupts in one blanking period.

Top module: `vbl_nmi_gen`

## Requirements
- R1: After reset the returned flag is 0 and `nmi_n` is 1.
- R2: With no read nearby, the returned flag is 0 on the dot before the set dot, and 1 on the set dot and on every later dot until cleared.
- R3: A status read clears the flag, so the returned flag is 0 on the dot after the read.
- R4: A read exactly one dot before the set dot returns 0 and blocks the flag from being set in that frame, so no NMI occurs. The block is lifted by the end-of-blank pulse and does not affect the next frame.
- R5: A read on the set dot or one dot after it returns 1 and yields no NMI falling edge in that frame. A read 2 to 4 dots before or 2 to 4 dots after the set dot leaves the NMI in place.
- R6: With the enable held high and no read, `nmi_n` first goes low (active-low: 0 means asserted) on the second dot after the set dot.
- R7: When the enable is dropped on the dot before the set dot, on the set dot, or on the dot after it, and stays low, no NMI occurs. When it is dropped 2, 3 or 4 dots after the set dot, one NMI still occurs.
- R8: Raising the enable while the flag is set drives `nmi_n` low on the next dot.
- R9: Within one blanking period, turning the enable off for one dot and then on again produces a second NMI falling edge.
- R10: On the end-of-blank dot the returned flag reads 0, and `nmi_n` is 1 on the following dot.
- R11: A status read while `nmi_n` is low releases it to 1 on the next dot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| vbl_start | input | 1 | One-dot pulse on the set dot |
| vbl_end | input | 1 | One-dot pulse on the end-of-blank dot |
| rd_stb | input | 1 | Status-read strobe for the current dot |
| nmi_en | input | 1 | Interrupt enable level from the CPU |
| flag_view | output | 1 | Flag value that a read on this dot returns |
| nmi_n | output | 1 | Active-low non-maskable interrupt |

## Verification
On every cycle the assertions check several relations. A read clears the flag and releases the interrupt. The end-of-blank pulse hides the flag. The interrupt line is never low unless the enable was high on the previous dot. A set flag with the enable high pulls the line low one dot later, and a read one dot before the set dot hides the flag on the set dot. The suppression and disable windows around the set dot, the exact dot of the first falling edge, and the count of falling edges per frame are only visible over a whole frame. The bench shows them with dot-offset sweeps of the read and of the enable drop, and with late-enable and toggle frames.

// File: rtl/vbl_nmi_pkg.sv
package vbl_nmi_pkg;

    // Events seen by the block on one dot
    typedef struct packed {
        logic vbl_on;   // set dot of vertical blank
        logic vbl_off;  // end-of-blank dot
        logic rd;       // status read on this dot
    } dot_evt_t;

    // Update chosen for the stored flag at the end of a dot
    typedef enum logic [1:0] {
        FL_HOLD = 2'd0,
        FL_SET  = 2'd1,
        FL_CLR  = 2'd2
    } flag_act_t;

    // A clear (end of blank or read) beats a set on the same dot
    function automatic flag_act_t pick_act(dot_evt_t e, logic blk);
        if (e.vbl_off || e.rd) return FL_CLR;
        if (e.vbl_on && !blk)  return FL_SET;
        return FL_HOLD;
    endfunction

    // Value a read on this dot returns
    function automatic logic view_of(logic stored, dot_evt_t e, logic blk);
        if (e.vbl_off) return 1'b0;
        return stored || (e.vbl_on && !blk);
    endfunction

    // Interrupt request for the next dot, built from the stored flag
    function automatic logic nmi_req(logic stored, logic en, logic rd, logic off);
        return stored && en && !rd && !off;
    endfunction

endpackage

// File: rtl/vbl_rd_tracker.sv
module vbl_rd_tracker
    import vbl_nmi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dot_evt_t evt,
    output logic     set_blk
);
    logic rd_prev_q;  // a read happened on the previous dot
    logic sup_q;      // setting blocked for the rest of this frame

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev_q <= 1'b0;
            sup_q     <= 1'b0;
        end else begin
            rd_prev_q <= evt.rd;
            if (evt.vbl_off)
                sup_q <= 1'b0;
            else if (evt.vbl_on && rd_prev_q)
                sup_q <= 1'b1;
        end
    end

    assign set_blk = sup_q || (evt.vbl_on && rd_prev_q);
endmodule

// File: rtl/vbl_flag_core.sv
module vbl_flag_core
    import vbl_nmi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dot_evt_t evt,
    input  logic     set_blk,
    output logic     flag_q,
    output logic     flag_view
);
    flag_act_t act;

    always_comb act = pick_act(evt, set_blk);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            unique case (act)
                FL_SET:  flag_q <= 1'b1;
                FL_CLR:  flag_q <= 1'b0;
                default: flag_q <= flag_q;
            endcase
        end
    end

    assign flag_view = view_of(flag_q, evt, set_blk);
endmodule

// File: rtl/vbl_nmi_drive.sv
module vbl_nmi_drive
    import vbl_nmi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flag_q,
    input  logic nmi_en,
    input  logic rd,
    input  logic vbl_off,
    output logic nmi_n
);
    logic nmi_q;

    always_ff @(posedge clk) begin
        if (rst) nmi_q <= 1'b0;
        else     nmi_q <= nmi_req(flag_q, nmi_en, rd, vbl_off);
    end

    assign nmi_n = ~nmi_q;
endmodule

// File: rtl/vbl_nmi_gen.sv
module vbl_nmi_gen
    import vbl_nmi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vbl_start,
    input  logic vbl_end,
    input  logic rd_stb,
    input  logic nmi_en,
    output logic flag_view,
    output logic nmi_n
);
    dot_evt_t evt;
    logic     set_blk;
    logic     flag_q;

    always_comb begin
        evt.vbl_on  = vbl_start;
        evt.vbl_off = vbl_end;
        evt.rd      = rd_stb;
    end

    vbl_rd_tracker u_trk (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .set_blk (set_blk)
    );

    vbl_flag_core u_flag (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .set_blk   (set_blk),
        .flag_q    (flag_q),
        .flag_view (flag_view)
    );

    vbl_nmi_drive u_nmi (
        .clk     (clk),
        .rst     (rst),
        .flag_q  (flag_q),
        .nmi_en  (nmi_en),
        .rd      (rd_stb),
        .vbl_off (vbl_end),
        .nmi_n   (nmi_n)
    );
endmodule

// File: rtl/vbl_nmi_chk.sv
module vbl_nmi_chk (
    input logic clk,
    input logic rst,
    input logic vbl_start,
    input logic vbl_end,
    input logic rd_stb,
    input logic nmi_en,
    input logic flag_view,
    input logic nmi_n
);
    p_read_clears_r3: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !flag_view);

    p_early_read_hides_r4: assert property (@(posedge clk) disable iff (rst)
        (vbl_start && $past(rd_stb)) |-> !flag_view);

    p_nmi_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        !nmi_n |-> $past(nmi_en));

    p_enabled_flag_pulls_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_view && nmi_en && !rd_stb && !vbl_end && !vbl_start) |=> !nmi_n);

    p_end_hides_flag_r10: assert property (@(posedge clk) disable iff (rst)
        vbl_end |-> !flag_view);

    p_end_releases_r10: assert property (@(posedge clk) disable iff (rst)
        vbl_end |=> nmi_n);

    p_read_releases_r11: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> nmi_n);
endmodule

bind vbl_nmi_gen vbl_nmi_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .vbl_start (vbl_start),
    .vbl_end   (vbl_end),
    .rd_stb    (rd_stb),
    .nmi_en    (nmi_en),
    .flag_view (flag_view),
    .nmi_n     (nmi_n)
);

// File: tb/vbl_nmi_gen_tb.sv
module vbl_nmi_gen_tb;
    localparam int FR = 24;  // dots per test frame
    localparam int S  = 8;   // set dot
    localparam int E  = 20;  // end-of-blank dot
    localparam int NEVER = 1000;

    logic clk = 1'b0;
    logic rst, vbl_start, vbl_end, rd_stb, nmi_en;
    logic flag_view, nmi_n;

    int total = 0;
    int bad   = 0;
    logic flag_log [FR];
    logic nmi_log  [FR];
    int   falls;
    int   first_low;

    always #5 clk = ~clk;

    vbl_nmi_gen u_dut (
        .clk(clk), .rst(rst), .vbl_start(vbl_start), .vbl_end(vbl_end),
        .rd_stb(rd_stb), .nmi_en(nmi_en), .flag_view(flag_view), .nmi_n(nmi_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One frame: read on dot rd_at, enable low on dots lo_from..lo_to-1
    task automatic run_frame(input int rd_at, input int lo_from, input int lo_to);
        logic prev;
        for (int t = 0; t < FR; t++) begin
            @(negedge clk);
            vbl_start = (t == S);
            vbl_end   = (t == E);
            rd_stb    = (t == rd_at);
            nmi_en    = !(t >= lo_from && t < lo_to);
            #1;
            flag_log[t] = flag_view;
            nmi_log[t]  = nmi_n;
        end
        @(negedge clk);
        vbl_start = 1'b0; vbl_end = 1'b0; rd_stb = 1'b0;
        falls = 0; first_low = -1; prev = 1'b1;
        for (int t = 0; t < FR; t++) begin
            if (!nmi_log[t] && prev) begin
                falls++;
                if (first_low < 0) first_low = t;
            end
            prev = nmi_log[t];
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; vbl_start = 1'b0; vbl_end = 1'b0; rd_stb = 1'b0; nmi_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 flag", flag_view, 0);
        chk("R1 nmi_n", nmi_n, 1);

        // Baseline frame
        run_frame(-NEVER, NEVER, NEVER);
        chk("R2 before set", flag_log[S-1], 0);
        chk("R2 on set", flag_log[S], 1);
        chk("R2 after set", flag_log[S+1], 1);
        chk("R6 first low dot", first_low, S+2);
        chk("R6 falls", falls, 1);
        chk("R10 flag on end dot", flag_log[E], 0);
        chk("R10 nmi after end", nmi_log[E+1], 1);

        // Read offset sweep
        for (int k = -4; k <= 4; k++) begin
            run_frame(S+k, NEVER, NEVER);
            chk($sformatf("R5 read value k=%0d", k), flag_log[S+k], (k >= 0) ? 1 : 0);
            if (k == -1) begin
                chk("R4 no nmi", falls, 0);
                chk("R4 flag stays clear", flag_log[S+3], 0);
            end else begin
                chk($sformatf("R5 nmi count k=%0d", k), falls, (k >= 2 || k <= -2) ? 1 : 0);
            end
            if (k >= 0)
                chk($sformatf("R3 cleared k=%0d", k), flag_log[S+k+1], 0);
            if (k >= 2)
                chk($sformatf("R11 release k=%0d", k), nmi_log[S+k+1], 1);
            if (k == -1) begin
                run_frame(-NEVER, NEVER, NEVER);
                chk("R4 next frame nmi", falls, 1);
                chk("R4 next frame flag", flag_log[S], 1);
            end
        end

        // Enable drop sweep
        for (int k = -4; k <= 4; k++) begin
            run_frame(-NEVER, S+k, NEVER);
            chk($sformatf("R7 disable k=%0d", k), falls, (k >= 2) ? 1 : 0);
        end

        // Late enable
        run_frame(-NEVER, 0, S+3);
        chk("R8 still high", nmi_log[S+3], 1);
        chk("R8 low next dot", nmi_log[S+4], 0);

        // Toggle for a second interrupt
        run_frame(-NEVER, S+6, S+7);
        chk("R9 falls", falls, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule